// File: doc/BRIEF.md
# Root Port Error Collector

This block sits at the top of a root port's error path and gathers the error messages that arrive there. Each message carries a two-bit severity code (correctable, non-fatal or fatal) and a 16-bit requester identifier. The block keeps a root error status word that records which classes of message have been seen. It flags when more than one message of a class has been seen, and when the first uncorrectable message of a burst was fatal. It holds the identifier of the first correctable and the first uncorrectable message so software can find the reporting function.

Software enables interrupt reporting per class through a three-bit command register and acknowledges status with write-one-to-clear. The interrupt leaves the block in one of two forms, chosen by a mode input. In the first form, a level line follows the enabled-and-pending condition. In the second, a one-cycle message request fires only when that condition turns from false to true, together with a message number. That number can be changed only by a separate loading input, never by the status clear.

Top module: `rp_err_collector`

## Requirements
- R1: After reset the status word, both identifier fields, the command register and the message number are zero, and the level and message outputs are low.
- R2: A correctable message (severity 0) captures its identifier into the correctable field and sets status bit 0 when bit 0 is clear. When bit 0 is already set, it sets status bit 1 and leaves the field unchanged.
- R3: A non-fatal (severity 1) or fatal (severity 2) message captures its identifier into the uncorrectable field and sets status bit 2 when bit 2 is clear. When bit 2 is already set, it sets status bit 3 and leaves the field unchanged.
- R4: A fatal message always sets status bit 6, and sets status bit 4 only when status bit 2 was clear before it. A non-fatal message sets status bit 5.
- R5: A message with severity code 3 changes no state.
- R6: A clear strobe zeroes every status bit whose mask bit is one. Mask bit 0 also zeroes the correctable field and mask bit 2 also zeroes the uncorrectable field. A message in the same cycle is applied after the clear, so the bits it sets end up set.
- R7: The pending condition is the OR of three terms: command bit 0 with status bit 0, command bit 1 with status bit 5, and command bit 2 with status bit 6. With the mode input low, the level output equals the pending condition and the message request stays low.
- R8: With the mode input high, the message request is high for exactly one cycle each time pending turns from false to true, whether a message or a command write caused it. It stays low while pending remains true, and the level output is low.
- R9: The message number changes only when the load input is high. Status clears and messages leave it unchanged.
- R10: Every register update from a message, clear, command write or load becomes visible on the outputs in the cycle after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | An error message is presented this cycle |
| msg_sev | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal, 3 reserved |
| msg_src | input | 16 | Requester identifier of the message |
| cmd_we | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 3 | Enables: bit0 correctable, bit1 non-fatal, bit2 fatal |
| sts_clr | input | 1 | Write-one-to-clear strobe for the status word |
| sts_clr_mask | input | 7 | Bits to clear in the status word |
| vec_load | input | 1 | Load strobe for the message number |
| vec_value | input | 5 | Message number to load |
| msi_mode | input | 1 | 1 selects pulsed message requests, 0 selects the level line |
| root_sts | output | 7 | Status word: 0 cor, 1 multi cor, 2 uncor, 3 multi uncor, 4 first fatal, 5 non-fatal, 6 fatal |
| cor_src | output | 16 | Identifier of the first correctable message |
| unc_src | output | 16 | Identifier of the first uncorrectable message |
| root_cmd | output | 3 | Command register contents |
| msg_num | output | 5 | Message number sent with requests |
| intx_out | output | 1 | Level interrupt |
| msi_req | output | 1 | One-cycle message interrupt request |

## Verification
The assertions check on every cycle the properties that hold locally. Identifier fields stay fixed once their class bit is set and not cleared. The first-fatal bit does not move while an uncorrectable message is already recorded. A reserved code leaves the status alone, and a clear with no message empties the masked bits. A message request never lasts two cycles and never appears outside message mode, and the message number holds without a load. The scenarios are the only way to show the orderings: a clear and a message in the same cycle, a command write that turns pending on with status already present, no second request while pending stays true, and the level line following pending across command changes. A randomized run compares every output against a bench model on each cycle.

// File: rtl/rpec_pkg.sv
package rpec_pkg;

  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2,
    SEV_RSVD     = 2'd3
  } sev_e;

  localparam int ST_W    = 7;
  localparam int ST_COR  = 0;
  localparam int ST_MCOR = 1;
  localparam int ST_UNC  = 2;
  localparam int ST_MUNC = 3;
  localparam int ST_FF   = 4;
  localparam int ST_NF   = 5;
  localparam int ST_FAT  = 6;

  localparam int CMD_W   = 3;
  localparam int CE_COR  = 0;
  localparam int CE_NF   = 1;
  localparam int CE_FAT  = 2;

  localparam int N_CLASS = 2;

endpackage

// File: rtl/rpec_status.sv
module rpec_status
  import rpec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 msg_valid,
  input  logic [1:0]           msg_sev,
  input  logic                 clr_en,
  input  logic [ST_W-1:0]      clr_mask,
  output logic [ST_W-1:0]      sts_q,
  output logic [ST_W-1:0]      sts_nxt,
  output logic [N_CLASS-1:0]   cap,
  output logic [N_CLASS-1:0]   zap
);

  logic [ST_W-1:0] base;
  logic            sts_en;
  sev_e            sev;

  assign sev    = sev_e'(msg_sev);
  assign sts_en = msg_valid | clr_en;

  always_comb begin
    base = sts_q;
    if (clr_en) begin
      base = sts_q & ~clr_mask;
    end
    sts_nxt = base;
    cap     = '0;
    if (msg_valid) begin
      case (sev)
        SEV_COR: begin
          if (base[ST_COR]) sts_nxt[ST_MCOR] = 1'b1;
          else              cap[0]           = 1'b1;
          sts_nxt[ST_COR] = 1'b1;
        end
        SEV_NONFATAL, SEV_FATAL: begin
          if (sev == SEV_FATAL) begin
            if (!base[ST_UNC]) sts_nxt[ST_FF] = 1'b1;
            sts_nxt[ST_FAT] = 1'b1;
          end else begin
            sts_nxt[ST_NF] = 1'b1;
          end
          if (base[ST_UNC]) sts_nxt[ST_MUNC] = 1'b1;
          else              cap[1]           = 1'b1;
          sts_nxt[ST_UNC] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign zap[0] = clr_en & clr_mask[ST_COR];
  assign zap[1] = clr_en & clr_mask[ST_UNC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else if (sts_en) begin
      sts_q <= sts_nxt;
    end
  end

  // R5: reserved severity leaves the status word untouched
  assert_rsvd_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd3 && !clr_en) |=> $stable(sts_q));

  // R6: a clear without a message empties the masked bits
  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !msg_valid) |=> ((sts_q & $past(clr_mask)) == '0));

  // R4: first-fatal bit holds while an uncorrectable message is recorded
  assert_first_fatal_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd2 && sts_q[ST_UNC] &&
     !(clr_en && (clr_mask[ST_UNC] || clr_mask[ST_FF])))
    |=> $stable(sts_q[ST_FF]));

endmodule

// File: rtl/rpec_src_field.sv
module rpec_src_field #(
  parameter int SRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic             zap,
  input  logic [SRC_W-1:0] src_in,
  output logic [SRC_W-1:0] src_q
);

  logic             en;
  logic [SRC_W-1:0] nxt;

  assign en = cap | zap;

  always_comb begin
    nxt = src_q;
    if (zap) nxt = '0;
    if (cap) nxt = src_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
    end else if (en) begin
      src_q <= nxt;
    end
  end

endmodule

// File: rtl/rpec_ctrl.sv
module rpec_ctrl
  import rpec_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic             vec_load,
  input  logic [VEC_W-1:0] vec_value,
  output logic [CMD_W-1:0] cmd_q,
  output logic [CMD_W-1:0] cmd_nxt,
  output logic [VEC_W-1:0] vec_q
);

  logic [VEC_W-1:0] vec_nxt;

  always_comb begin
    cmd_nxt = cmd_q;
    if (cmd_we) cmd_nxt = cmd_wdata;
    vec_nxt = vec_q;
    if (vec_load) vec_nxt = vec_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_we) begin
      cmd_q <= cmd_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (vec_load) begin
      vec_q <= vec_nxt;
    end
  end

  // R9: message number moves only on a load
  assert_vec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_load |=> $stable(vec_q));

endmodule

// File: rtl/rpec_irq.sv
module rpec_irq
  import rpec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ST_W-1:0]  sts_nxt,
  input  logic [CMD_W-1:0] cmd_nxt,
  input  logic             msi_mode,
  output logic             intx_out,
  output logic             msi_req
);

  logic [CMD_W-1:0] rcv_nxt;
  logic             pend_nxt;
  logic             pend_q;
  logic             msi_nxt;

  assign rcv_nxt[CE_COR] = sts_nxt[ST_COR];
  assign rcv_nxt[CE_NF]  = sts_nxt[ST_NF];
  assign rcv_nxt[CE_FAT] = sts_nxt[ST_FAT];

  assign pend_nxt = |(rcv_nxt & cmd_nxt);
  assign msi_nxt  = msi_mode & pend_nxt & ~pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      msi_req <= 1'b0;
    end else begin
      pend_q  <= pend_nxt;
      msi_req <= msi_nxt;
    end
  end

  assign intx_out = ~msi_mode & pend_q;

  // R8: a request never lasts two cycles
  assert_msi_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |=> !msi_req);

  // R7: no request is produced from a cycle in level mode
  assert_msi_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_mode |=> !msi_req);

endmodule

// File: rtl/rp_err_collector.sv
module rp_err_collector
  import rpec_pkg::*;
#(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [1:0]       msg_sev,
  input  logic [SRC_W-1:0] msg_src,
  input  logic             cmd_we,
  input  logic [2:0]       cmd_wdata,
  input  logic             sts_clr,
  input  logic [6:0]       sts_clr_mask,
  input  logic             vec_load,
  input  logic [VEC_W-1:0] vec_value,
  input  logic             msi_mode,
  output logic [6:0]       root_sts,
  output logic [SRC_W-1:0] cor_src,
  output logic [SRC_W-1:0] unc_src,
  output logic [2:0]       root_cmd,
  output logic [VEC_W-1:0] msg_num,
  output logic             intx_out,
  output logic             msi_req
);

  logic [ST_W-1:0]    sts_q;
  logic [ST_W-1:0]    sts_nxt;
  logic [N_CLASS-1:0] cap;
  logic [N_CLASS-1:0] zap;
  logic [CMD_W-1:0]   cmd_q;
  logic [CMD_W-1:0]   cmd_nxt;
  logic [SRC_W-1:0]   src_arr [N_CLASS];

  rpec_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_sev   (msg_sev),
    .clr_en    (sts_clr),
    .clr_mask  (sts_clr_mask),
    .sts_q     (sts_q),
    .sts_nxt   (sts_nxt),
    .cap       (cap),
    .zap       (zap)
  );

  for (genvar g = 0; g < N_CLASS; g++) begin : g_src
    rpec_src_field #(.SRC_W(SRC_W)) u_src (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap    (cap[g]),
      .zap    (zap[g]),
      .src_in (msg_src),
      .src_q  (src_arr[g])
    );
  end

  rpec_ctrl #(.VEC_W(VEC_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .cmd_wdata (cmd_wdata),
    .vec_load  (vec_load),
    .vec_value (vec_value),
    .cmd_q     (cmd_q),
    .cmd_nxt   (cmd_nxt),
    .vec_q     (msg_num)
  );

  rpec_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sts_nxt  (sts_nxt),
    .cmd_nxt  (cmd_nxt),
    .msi_mode (msi_mode),
    .intx_out (intx_out),
    .msi_req  (msi_req)
  );

  assign root_sts = sts_q;
  assign root_cmd = cmd_q;
  assign cor_src  = src_arr[0];
  assign unc_src  = src_arr[1];

  // R2: correctable identifier holds once recorded and not cleared
  assert_cor_src_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (root_sts[ST_COR] && !(sts_clr && sts_clr_mask[ST_COR])) |=> $stable(cor_src));

  // R3: uncorrectable identifier holds once recorded and not cleared
  assert_unc_src_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (root_sts[ST_UNC] && !(sts_clr && sts_clr_mask[ST_UNC])) |=> $stable(unc_src));

endmodule

// File: tb/test_rp_err_collector.sv
module test_rp_err_collector;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        msg_valid;
  logic [1:0]  msg_sev;
  logic [15:0] msg_src;
  logic        cmd_we;
  logic [2:0]  cmd_wdata;
  logic        sts_clr;
  logic [6:0]  sts_clr_mask;
  logic        vec_load;
  logic [4:0]  vec_value;
  logic        msi_mode;
  logic [6:0]  root_sts;
  logic [15:0] cor_src;
  logic [15:0] unc_src;
  logic [2:0]  root_cmd;
  logic [4:0]  msg_num;
  logic        intx_out;
  logic        msi_req;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [6:0]  m_sts;
  logic [15:0] m_csrc, m_usrc;
  logic [2:0]  m_cmd;
  logic [4:0]  m_vec;
  logic        m_pq, m_msi;

  always #4 clk = ~clk;

  rp_err_collector i_rp_err_collector (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sev(msg_sev),
    .msg_src(msg_src), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .sts_clr(sts_clr), .sts_clr_mask(sts_clr_mask), .vec_load(vec_load),
    .vec_value(vec_value), .msi_mode(msi_mode), .root_sts(root_sts),
    .cor_src(cor_src), .unc_src(unc_src), .root_cmd(root_cmd),
    .msg_num(msg_num), .intx_out(intx_out), .msi_req(msi_req)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic idle();
    msg_valid = 0; msg_sev = 0; msg_src = 0; cmd_we = 0; cmd_wdata = 0;
    sts_clr = 0; sts_clr_mask = 0; vec_load = 0; vec_value = 0;
  endtask

  function automatic logic exp_pend(input logic [6:0] s, input logic [2:0] c);
    return (c[0] & s[0]) | (c[1] & s[5]) | (c[2] & s[6]);
  endfunction

  task automatic model_step();
    logic [6:0]  s;
    logic [15:0] cs, us;
    logic        p;
    s = m_sts; cs = m_csrc; us = m_usrc;
    if (sts_clr) begin
      s = s & ~sts_clr_mask;
      if (sts_clr_mask[0]) cs = '0;
      if (sts_clr_mask[2]) us = '0;
    end
    if (msg_valid && msg_sev != 2'd3) begin
      if (msg_sev == 2'd0) begin
        if (s[0]) s[1] = 1'b1; else cs = msg_src;
        s[0] = 1'b1;
      end else begin
        if (msg_sev == 2'd2) begin
          if (!s[2]) s[4] = 1'b1;
          s[6] = 1'b1;
        end else s[5] = 1'b1;
        if (s[2]) s[3] = 1'b1; else us = msg_src;
        s[2] = 1'b1;
      end
    end
    if (cmd_we) m_cmd = cmd_wdata;
    if (vec_load) m_vec = vec_value;
    m_sts = s; m_csrc = cs; m_usrc = us;
    p = exp_pend(m_sts, m_cmd);
    m_msi = msi_mode & p & ~m_pq;
    m_pq = p;
  endtask

  task automatic compare_all();
    chk("R2 R3 R4 R6 R10 status", {25'd0, root_sts}, {25'd0, m_sts});
    chk("R2 R6 cor_src", {16'd0, cor_src}, {16'd0, m_csrc});
    chk("R3 R6 unc_src", {16'd0, unc_src}, {16'd0, m_usrc});
    chk("R10 root_cmd", {29'd0, root_cmd}, {29'd0, m_cmd});
    chk("R9 msg_num", {27'd0, msg_num}, {27'd0, m_vec});
    chk("R7 intx_out", {31'd0, intx_out}, {31'd0, ~msi_mode & m_pq});
    chk("R8 msi_req", {31'd0, msi_req}, {31'd0, m_msi});
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic send(input logic [1:0] sev, input logic [15:0] src);
    msg_valid = 1; msg_sev = sev; msg_src = src;
    cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    rst_n = 0; msi_mode = 1; idle();
    m_sts = 0; m_csrc = 0; m_usrc = 0; m_cmd = 0; m_vec = 0; m_pq = 0; m_msi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    compare_all();
    chk("R1 status zero", {25'd0, root_sts}, 32'd0);

    // R8: enable cor, first cor message triggers one request
    cmd_we = 1; cmd_wdata = 3'b001; cyc();
    chk("R8 no request without status", {31'd0, msi_req}, 32'd0);
    send(2'd0, 16'h1234);
    chk("R2 first cor captures", {16'd0, cor_src}, 32'h1234);
    chk("R8 request on rise", {31'd0, msi_req}, 32'd1);
    cyc();
    chk("R8 request one cycle", {31'd0, msi_req}, 32'd0);
    send(2'd0, 16'h5678);
    chk("R2 second cor keeps id", {16'd0, cor_src}, 32'h1234);
    chk("R2 multi cor set", {31'd0, root_sts[1]}, 32'd1);
    chk("R8 no request while pending", {31'd0, msi_req}, 32'd0);

    // R4: fatal first then non-fatal
    send(2'd2, 16'hAAAA);
    chk("R4 first fatal set", {31'd0, root_sts[4]}, 32'd1);
    chk("R3 unc id captured", {16'd0, unc_src}, 32'hAAAA);
    send(2'd1, 16'hBBBB);
    chk("R3 multi uncor set", {31'd0, root_sts[3]}, 32'd1);
    chk("R4 nonfatal bit set", {31'd0, root_sts[5]}, 32'd1);

    // R5: reserved code
    send(2'd3, 16'hCCCC);
    chk("R5 reserved ignored", {25'd0, root_sts}, {25'd0, 7'b1111111 & m_sts});

    // R6: clear all and same-cycle message
    sts_clr = 1; sts_clr_mask = 7'h7F; msg_valid = 1; msg_sev = 2'd1; msg_src = 16'h0F0F;
    cyc();
    chk("R6 message wins over clear", {25'd0, root_sts}, 32'b0100100);
    chk("R6 unc id recaptured", {16'd0, unc_src}, 32'h0F0F);
    chk("R6 cor id zeroed", {16'd0, cor_src}, 32'd0);

    // R8: command write raises pending
    cmd_we = 1; cmd_wdata = 3'b010; cyc();
    chk("R8 request from command write", {31'd0, msi_req}, 32'd1);

    // R7: level mode follows pending
    msi_mode = 0; cyc();
    chk("R7 level high", {31'd0, intx_out}, 32'd1);
    cmd_we = 1; cmd_wdata = 3'b000; cyc();
    chk("R7 level low after disable", {31'd0, intx_out}, 32'd0);

    // R9: vector load
    vec_load = 1; vec_value = 5'd19; cyc();
    chk("R9 vector loaded", {27'd0, msg_num}, 32'd19);
    sts_clr = 1; sts_clr_mask = 7'h7F; cyc();
    chk("R9 vector kept on clear", {27'd0, msg_num}, 32'd19);

    // random phase
    seed = $urandom(32'd2024);
    msi_mode = 1;
    for (int i = 0; i < 4000; i++) begin
      msg_valid = ($urandom % 2) == 0;
      msg_sev   = 2'($urandom % 4);
      msg_src   = 16'($urandom);
      if (($urandom % 10) == 0) begin sts_clr = 1; sts_clr_mask = 7'($urandom); end
      if (($urandom % 8) == 0) begin cmd_we = 1; cmd_wdata = 3'($urandom); end
      if (($urandom % 20) == 0) begin vec_load = 1; vec_value = 5'($urandom); end
      if (($urandom % 50) == 0) msi_mode = ~msi_mode;
      cyc();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule